// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This controller merges six reset requests into one internal reset for the rest of the chip and then runs a timed release sequence. The six requests are an active-low external pin, a watchdog, a power-on event, a low-voltage detector, a supply-good monitor and a halt wake-up request. When every request has gone away and the supply is reported good, the controller enables the oscillator. It then waits a fixed stabilization time and a second, clock-source-dependent time before it lets the processor run. Analog detection, spike filtering and the oscillator itself sit outside the block and reach it as digital levels.

The second wait is short and fixed when the internal oscillator drives the chip. When a crystal drives the chip, the second wait is scaled by an 8-bit wake-up prescaler. Any new request during either wait aborts the sequence and starts it again. The supply monitor can be disabled. In that case a power-on event locks the controller in reset until a supply-at-zero indication arrives. A sticky cause register records which requests have occurred since the last power-on event.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While any request is active, `core_rst` is 1, and from the next clock edge `osc_en` and `run_en` are 0. The requests are `ext_rst_n` low, `wdg_req`, `por_evt`, `lvd_req`, `hwk_req`, and `supply_ok` low while `pdd_en` is 1.
- R2: `core_rst` rises in the same instant that `ext_rst_n` falls, with no clock edge in between.
- R3: The last request is removed between clock edges. `osc_en` rises on the third clock edge after that, once the synchronizer has cleared and the supply condition is met. It stays high while the sequence and the run phase last.
- R4: With `clk_xtal` = 0, `run_en` rises on the 135th clock edge after release. That is 3 + 128 + 4 edges.
- R5: With `clk_xtal` = 1, the second wait is (`wake_pre`+1)×128 cycles, so `run_en` rises on edge 131 + (`wake_pre`+1)×128. `wake_pre` is sampled when the 128-cycle count ends, and later changes to it have no effect.
- R6: With `pdd_en` = 1, a low `supply_ok` holds the block in reset. The release is timed from the rise of `supply_ok`.
- R7: With `pdd_en` = 0, `supply_ok` is ignored, and after a power-on event the block stays in reset until a pulse on `supply_zero`. `run_en` then rises on the 134th edge after the pulse starts, when the internal clock is selected.
- R8: A request that arrives during the stabilization count or the second count drops `osc_en` and `run_en`. The full sequence is then timed again from the release of that request.
- R9: Once high, `run_en` stays high until the next request.
- R10: `rst_cause` holds a sticky bit per source: bit 0 external pin, 1 watchdog, 2 power-on, 3 low-voltage, 4 supply-fail, 5 halt wake-up. A power-on event clears the other bits, leaving only the sources active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequence |
| ext_rst_n | input | 1 | External reset pin, active low, only read |
| wdg_req | input | 1 | Watchdog reset request |
| por_evt | input | 1 | Power-on event |
| lvd_req | input | 1 | Low-voltage detector request |
| hwk_req | input | 1 | Halt wake-up reset request |
| supply_ok | input | 1 | Supply-good level from the supply monitor |
| pdd_en | input | 1 | Supply monitor enable |
| supply_zero | input | 1 | Supply has been at zero (full power cycle) |
| clk_xtal | input | 1 | 1 = crystal clock selected, 0 = internal clock |
| wake_pre | input | 8 | Wake-up prescaler for the crystal wait |
| core_rst | output | 1 | Internal reset, active high |
| osc_en | output | 1 | Oscillator enable |
| run_en | output | 1 | Processor may run |
| rst_cause | output | 6 | Sticky reset-cause bits |

## Verification
The hardest state to reach is the power-on lock with the supply monitor disabled. To reach it, the bench clears `pdd_en`, raises the supply-good signal high (where it must be ignored) and raises `por_evt`. It then waits hundreds of cycles while checking that the sequence never starts, and only then sends the supply-zero pulse. Aborts are forced by raising a second request partway through the stabilization count. Each release pushes its expected `run_en` edge into a scoreboard queue. A monitor pops that entry when `run_en` rises, and any rise with nothing queued counts as an error. A change to `wake_pre` during the crystal wait shows that the length was captured earlier.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int NSRC    = 6;
  localparam int SRC_EXT = 0;
  localparam int SRC_WDG = 1;
  localparam int SRC_POR = 2;
  localparam int SRC_LVD = 3;
  localparam int SRC_PDD = 4;
  localparam int SRC_HWK = 5;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_STAB = 2'd1,
    ST_POST = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rsc_req_sync.sv
module rsc_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic req,
  output logic hold
);
  logic [STAGES-1:0] chain;

  // set at once, clear only after STAGES clean edges
  always_ff @(posedge clk or posedge req) begin
    if (req) chain <= '1;
    else     chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign hold = chain[STAGES-1];
endmodule

// File: rtl/rsc_delay_timer.sv
module rsc_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = run && (cnt == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!run || expired) cnt <= '0;
    else                 cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/rsc_cause_log.sv
module rsc_cause_log #(
  parameter int NS      = 6,
  parameter int POR_BIT = 2
) (
  input  logic          clk,
  input  logic [NS-1:0] src_vec,
  output logic [NS-1:0] cause
);
  always_ff @(posedge clk) begin
    if (src_vec[POR_BIT]) cause <= src_vec;
    else                  cause <= cause | src_vec;
  end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rsc_pkg::*;
#(
  parameter int STAB_CYC    = 128,
  parameter int SHORT_CYC   = 4,
  parameter int SCALE_LG    = 7,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             ext_rst_n,
  input  logic             wdg_req,
  input  logic             por_evt,
  input  logic             lvd_req,
  input  logic             hwk_req,
  input  logic             supply_ok,
  input  logic             pdd_en,
  input  logic             supply_zero,
  input  logic             clk_xtal,
  input  logic [PRE_W-1:0] wake_pre,
  output logic             core_rst,
  output logic             osc_en,
  output logic             run_en,
  output logic [NSRC-1:0]  rst_cause
);
  localparam int CNT_W = PRE_W + SCALE_LG + 1;

  logic [NSRC-1:0]  src_vec;
  logic             req_any;
  logic             hold;
  logic             lock_q;
  logic             go;
  seq_state_t       state;
  logic [CNT_W-1:0] post_len;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] xtal_len;
  logic             tmr_run;
  logic             tmr_done;

  always_comb begin
    src_vec          = '0;
    src_vec[SRC_EXT] = ~ext_rst_n;
    src_vec[SRC_WDG] = wdg_req;
    src_vec[SRC_POR] = por_evt;
    src_vec[SRC_LVD] = lvd_req;
    src_vec[SRC_PDD] = pdd_en & ~supply_ok;
    src_vec[SRC_HWK] = hwk_req;
  end

  assign req_any = |src_vec;

  rsc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .req  (req_any),
    .hold (hold)
  );

  // power-on with monitor off: wait for a full power cycle
  always_ff @(posedge clk) begin
    if (por_evt)          lock_q <= ~pdd_en;
    else if (supply_zero) lock_q <= 1'b0;
  end

  assign go       = pdd_en ? supply_ok : ~lock_q;
  assign xtal_len = (CNT_W'(wake_pre) + CNT_W'(1)) << SCALE_LG;
  assign tmr_run  = (state == ST_STAB) || (state == ST_POST);
  assign lim      = (state == ST_STAB) ? CNT_W'(STAB_CYC) : post_len;

  rsc_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .run     (tmr_run),
    .limit   (lim),
    .expired (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (hold) begin
      state    <= ST_WAIT;
      osc_en   <= 1'b0;
      run_en   <= 1'b0;
      post_len <= CNT_W'(SHORT_CYC);
    end else begin
      case (state)
        ST_WAIT: if (go) begin
          state  <= ST_STAB;
          osc_en <= 1'b1;
        end
        ST_STAB: if (tmr_done) begin
          state    <= ST_POST;
          post_len <= clk_xtal ? xtal_len : CNT_W'(SHORT_CYC);
        end
        ST_POST: if (tmr_done) begin
          state  <= ST_RUN;
          run_en <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // pin path is combinational so a pin reset is seen with no clock
  assign core_rst = req_any | ~run_en;

  rsc_cause_log #(.NS(NSRC), .POR_BIT(SRC_POR)) u_cause (
    .clk     (clk),
    .src_vec (src_vec),
    .cause   (rst_cause)
  );
endmodule

// File: rtl/rsc_checker.sv
module rsc_checker (
  input logic       clk,
  input logic       ext_rst_n,
  input logic       wdg_req,
  input logic       por_evt,
  input logic       lvd_req,
  input logic       hwk_req,
  input logic       supply_ok,
  input logic       pdd_en,
  input logic       core_rst,
  input logic       osc_en,
  input logic       run_en,
  input logic [5:0] rst_cause
);
  logic any_src;
  assign any_src = !ext_rst_n || wdg_req || por_evt || lvd_req || hwk_req ||
                   (pdd_en && !supply_ok);

  a_r1_src_stops_seq: assert property (@(posedge clk) disable iff (por_evt)
    any_src |=> (!run_en && !osc_en));

  a_r2_pin_forces_rst: assert property (@(posedge clk) disable iff (por_evt)
    !ext_rst_n |-> core_rst);

  a_r3_osc_leads_run: assert property (@(posedge clk) disable iff (por_evt)
    run_en |-> osc_en);

  a_r6_supply_low_holds: assert property (@(posedge clk) disable iff (por_evt)
    (pdd_en && !supply_ok) |=> !osc_en);

  a_r9_run_holds: assert property (@(posedge clk) disable iff (por_evt)
    (run_en && !any_src) |=> run_en);

  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (por_evt)
    1'b1 |=> ((rst_cause & $past(rst_cause)) == $past(rst_cause)));
endmodule

bind rst_seq_ctrl rsc_checker u_chk (
  .clk       (clk),
  .ext_rst_n (ext_rst_n),
  .wdg_req   (wdg_req),
  .por_evt   (por_evt),
  .lvd_req   (lvd_req),
  .hwk_req   (hwk_req),
  .supply_ok (supply_ok),
  .pdd_en    (pdd_en),
  .core_rst  (core_rst),
  .osc_en    (osc_en),
  .run_en    (run_en),
  .rst_cause (rst_cause)
);

// File: tb/tb_rst_seq_ctrl.sv
module tb_rst_seq_ctrl;
  logic clk = 1'b0;
  logic ext_rst_n = 1'b1, wdg_req = 1'b0, por_evt = 1'b1, lvd_req = 1'b0;
  logic hwk_req = 1'b0, supply_ok = 1'b1, pdd_en = 1'b1, supply_zero = 1'b0;
  logic clk_xtal = 1'b0;
  logic [7:0] wake_pre = 8'd0;
  logic core_rst, osc_en, run_en;
  logic [5:0] rst_cause;

  int tests = 0, fails = 0, cyc = 0;
  int exp_q[$];
  logic prev_run = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rst_seq_ctrl dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdg_req(wdg_req), .por_evt(por_evt),
    .lvd_req(lvd_req), .hwk_req(hwk_req), .supply_ok(supply_ok), .pdd_en(pdd_en),
    .supply_zero(supply_zero), .clk_xtal(clk_xtal), .wake_pre(wake_pre),
    .core_rst(core_rst), .osc_en(osc_en), .run_en(run_en), .rst_cause(rst_cause)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: pops the expected rise cycle when run_en goes high
  always @(negedge clk) begin
    if (run_en === 1'b1 && prev_run !== 1'b1) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected run_en rise", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R4/R5/R7 run_en rise cycle", cyc, e);
      end
    end
    prev_run <= run_en;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_run(input int lat);
    exp_q.push_back(cyc + lat);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, "R4 run_en never rose", exp_q.size(), 0);
    cycles(2);
  endtask

  task automatic pulse_wdg_and_release(input int lat);
    wdg_req = 1'b1; cycles(3); wdg_req = 1'b0; expect_run(lat);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cycles(5);
    check(core_rst == 1'b1, "R1 reset state core_rst", core_rst, 1);
    check(osc_en == 1'b0 && run_en == 1'b0, "R1 reset state osc/run", {osc_en, run_en}, 0);
    check(rst_cause == 6'b000100, "R10 cause after power-on", rst_cause, 6'b000100);

    // R4: internal clock, release power-on
    por_evt = 1'b0; expect_run(135);
    cycles(2);
    check(osc_en == 1'b0, "R3 osc_en not yet", osc_en, 0);
    cycles(1);
    check(osc_en == 1'b1, "R3 osc_en on third edge", osc_en, 1);
    wait_drain();
    check(core_rst == 1'b0, "R4 core_rst released", core_rst, 0);
    cycles(20);
    check(run_en == 1'b1, "R9 run_en held", run_en, 1);

    // R2: pin reset is immediate, before any edge
    ext_rst_n = 1'b0; #1;
    check(core_rst == 1'b1, "R2 core_rst immediate", core_rst, 1);
    check(run_en == 1'b1, "R2 run_en still registered high", run_en, 1);
    cycles(1);
    check(run_en == 1'b0 && osc_en == 1'b0, "R1 pin reset drops run/osc", {osc_en, run_en}, 0);
    cycles(2);
    check(rst_cause == 6'b000101, "R10 ext bit set", rst_cause, 6'b000101);
    ext_rst_n = 1'b1; expect_run(135);
    wait_drain();

    // R1/R10: other sources
    lvd_req = 1'b1; cycles(2); lvd_req = 1'b0; expect_run(135); wait_drain();
    hwk_req = 1'b1; cycles(2); hwk_req = 1'b0; expect_run(135); wait_drain();
    pulse_wdg_and_release(135); wait_drain();
    check(rst_cause == 6'b101111, "R10 cause accumulates", rst_cause, 6'b101111);

    // R5: crystal clock
    clk_xtal = 1'b1; wake_pre = 8'd0;
    pulse_wdg_and_release(131 + 128); wait_drain();
    wake_pre = 8'd3;
    pulse_wdg_and_release(131 + 512); wait_drain();
    wake_pre = 8'd2;
    pulse_wdg_and_release(131 + 384);
    cycles(150); wake_pre = 8'd0;
    wait_drain();
    check(run_en == 1'b1, "R5 late wake_pre change ignored", run_en, 1);

    // R8: abort mid-stabilization and mid-second count
    clk_xtal = 1'b0;
    wdg_req = 1'b1; cycles(3); wdg_req = 1'b0;
    cycles(60);
    check(osc_en == 1'b1, "R8 stabilization running", osc_en, 1);
    lvd_req = 1'b1; cycles(1);
    check(osc_en == 1'b0, "R8 abort drops osc_en", osc_en, 0);
    cycles(1); lvd_req = 1'b0; expect_run(135);
    wait_drain();
    clk_xtal = 1'b1; wake_pre = 8'd1;
    wdg_req = 1'b1; cycles(3); wdg_req = 1'b0;
    cycles(200);
    hwk_req = 1'b1; cycles(2); hwk_req = 1'b0; expect_run(131 + 256);
    wait_drain();
    clk_xtal = 1'b0;

    // R6: supply low holds reset
    supply_ok = 1'b0; cycles(10);
    check(core_rst == 1'b1 && osc_en == 1'b0, "R6 supply low holds", {core_rst, osc_en}, 2);
    supply_ok = 1'b1; expect_run(135);
    wait_drain();

    // R7: monitor disabled, power-on locks until supply_zero
    pdd_en = 1'b0; supply_ok = 1'b0;
    por_evt = 1'b1; cycles(3); por_evt = 1'b0;
    check(rst_cause == 6'b000100, "R10 power-on clears cause", rst_cause, 6'b000100);
    supply_ok = 1'b1;
    cycles(300);
    check(run_en == 1'b0 && osc_en == 1'b0 && core_rst == 1'b1, "R7 locked in reset",
          {core_rst, osc_en, run_en}, 4);
    supply_zero = 1'b1; expect_run(134); cycles(1); supply_zero = 1'b0;
    wait_drain();
    check(core_rst == 1'b0, "R7 released after power cycle", core_rst, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule